// File: doc/BRIEF.md
# GPIO Pin Configuration Register Bank

This block is the register file of a general-purpose I/O controller for up to 94 pins. Software reaches it through a plain 32-bit register port: a write strobe, a byte address and write data, with read data returned combinationally for whatever address is presented. Each pin owns two configuration words. The first holds the pin's function select, direction, driven level, sampled level and interrupt trigger style. The second holds an input-sense disable and a two-bit weak-pull code. A bitmap, one bit per pin and preset at reset from a parameter, records which pins firmware leaves free for general use. A single control word picks which of two host interrupt lines the controller signals on.

From the stored settings the block drives each pad's output value and output enable. It samples each pad's input through a two-flop synchronizer. Interrupt status and enable banks live in a neighbouring block, which decodes the trigger fields at their fixed bit positions. Addresses that fall past the last pin or on no register read as zero and change nothing.

Top module: `gpcfg_bank`

## Requirements
- R1: Register map (byte addresses, bits [1:0] ignored): the ownership bitmap for pin p is bit p%32 of the word at 4*(p/32), from 0x00; the control word is at 0x7C; pin p's first config word is at 0x100+8*p and its second at 0x104+8*p. Reads return the addressed word in the same cycle. A write takes effect at the rising clock edge where wr_en is high.
- R2: After a synchronous active-low reset, every first config word reads 0x00000004 (native function, input). Every second config word reads 0x00000004 (sense disabled, pull 0). The control word reads 0, pad_oe and pad_out are all 0, and the ownership bitmap equals parameter OWN_INIT masked to the implemented pins.
- R3: First config word fields: bit 0 function select (1 = GPIO, 0 = native), bit 2 direction (1 = input, 0 = output), bit 3 trigger invert, bit 4 trigger style (1 = level, 0 = edge), bit 31 driven level, bit 30 sampled input (read-only). All other bits read 0 and ignore writes.
- R4: Second config word fields: bit 2 input-sense disable, bits [1:0] weak-pull code. All other bits read 0 and ignore writes.
- R5: pad_oe[p] is 1 exactly when pin p has function select 1 and direction 0. pad_out[p] equals bit 31 of its first word while pad_oe[p] is 1, and is 0 otherwise. The pads change only at the edge that completes a write.
- R6: With sense enabled (second word bit 2 = 0), bit 30 of pin p's first word reads pad_in[p] as captured two rising edges earlier. With sense disabled it reads 0. Writing bit 30 has no effect.
- R7: Ownership bits are read/write. Bits for pins at or beyond NUM_PINS read 0 and ignore writes.
- R8: Control bit 0 selects the host interrupt line (0 = first line, 1 = second line) and drives irq_sel. The other control bits read 0. irq_sel changes only by a write to the control word.
- R9: A read of any other address returns 0, including pin words of pins at or beyond NUM_PINS and ownership words past the last one. A write to such an address changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | ADDR_W (12) | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| pad_in | input | NUM_PINS (94) | Raw pad input levels |
| pad_out | output | NUM_PINS (94) | Pad output levels |
| pad_oe | output | NUM_PINS (94) | Pad output enables |
| irq_sel | output | 1 | Host interrupt line select |

## Verification
The hardest situation to reach is the sampled-input bit at the exact moment a pad toggles. It must lag by two edges, and it must read zero whenever sensing is off, even though the synchronizer keeps running underneath. The bench holds a pad quiet, toggles it and reads the pin's first word after one edge and again after two. It then repeats the read with sensing disabled. Random writes land on a mix of real pin words, pins just past the last one, the spare ownership slot and the gap before the pin region. After each write a read-back and the pad outputs are compared with a model.

// File: rtl/gpcfg_pkg.sv
// Shared constants and types for the GPIO configuration register bank.
// Assumes byte addressing with 32-bit words; bit positions below are
// decoded by the neighbouring interrupt block and must not move.
package gpcfg_pkg;

    localparam int unsigned CFG_BASE  = 32'h100;
    localparam int unsigned CTL_ADDR  = 32'h7C;

    localparam int C1_OUT   = 31;
    localparam int C1_IN    = 30;
    localparam int C1_TRIG  = 4;
    localparam int C1_INV   = 3;
    localparam int C1_DIR   = 2;
    localparam int C1_USE   = 0;
    localparam int C2_NOSNS = 2;

    typedef struct packed {
        logic       out_lvl;
        logic       trig_lvl;
        logic       trig_inv;
        logic       dir_in;
        logic       use_gpio;
        logic       sense_off;
        logic [1:0] pull;
    } pin_cfg_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_OWN,
        SEL_CTL,
        SEL_CFG1,
        SEL_CFG2
    } sel_e;

endpackage

// File: rtl/gpcfg_decode.sv
// Address decoder: classifies a byte address into ownership word, control
// word, per-pin config word or nothing. Assumes word-aligned use; bits
// [1:0] are ignored. Pins at or beyond NUM_PINS decode to nothing.
module gpcfg_decode
    import gpcfg_pkg::*;
#(
    parameter int NUM_PINS  = 94,
    parameter int ADDR_W    = 12,
    parameter int OWN_WORDS = (NUM_PINS + 31) / 32,
    parameter int PIN_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
    parameter int OWN_IW    = (OWN_WORDS > 1) ? $clog2(OWN_WORDS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output logic [PIN_W-1:0]  pin,
    output logic [OWN_IW-1:0] word
);

    logic [31:0] a32;
    logic [31:0] pofs;
    logic [31:0] pidx;
    logic        unused_lsb;

    assign a32        = 32'({addr[ADDR_W-1:2], 2'b00});
    assign pofs       = a32 - CFG_BASE;
    assign pidx       = pofs >> 3;
    assign unused_lsb = ^addr[1:0];

    // Classify the address into one register kind.
    always_comb begin
        sel  = SEL_NONE;
        pin  = '0;
        word = '0;
        if (a32 < 32'(OWN_WORDS * 4)) begin
            sel  = SEL_OWN;
            word = a32[2 +: OWN_IW];
        end else if (a32 == CTL_ADDR) begin
            sel = SEL_CTL;
        end else if (a32 >= CFG_BASE && pidx < 32'(NUM_PINS)) begin
            sel = pofs[2] ? SEL_CFG2 : SEL_CFG1;
            pin = pidx[PIN_W-1:0];
        end
    end

endmodule

// File: rtl/gpcfg_pin.sv
// One pin's two configuration words, its input synchronizer and pad drive.
// Assumes wr1/wr2 are already qualified by address decode.
module gpcfg_pin
    import gpcfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr1,
    input  logic        wr2,
    input  logic [31:0] wdata,
    input  logic        pad_in,
    output logic [31:0] rd1,
    output logic [31:0] rd2,
    output logic        pad_out,
    output logic        pad_oe
);

    pin_cfg_t   cfg;
    logic [1:0] sync_q;
    logic       sensed;
    logic       unused_wbits;

    assign unused_wbits = ^wdata[30:5];

    // Hold the configuration fields; the input level is never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '{out_lvl: 1'b0, trig_lvl: 1'b0, trig_inv: 1'b0,
                     dir_in: 1'b1, use_gpio: 1'b0, sense_off: 1'b1,
                     pull: 2'b00};
        end else begin
            if (wr1) begin
                cfg.out_lvl  <= wdata[C1_OUT];
                cfg.trig_lvl <= wdata[C1_TRIG];
                cfg.trig_inv <= wdata[C1_INV];
                cfg.dir_in   <= wdata[C1_DIR];
                cfg.use_gpio <= wdata[C1_USE];
            end
            if (wr2) begin
                cfg.sense_off <= wdata[C2_NOSNS];
                cfg.pull      <= wdata[1:0];
            end
        end
    end

    // Two-flop synchronizer on the raw pad level.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b00;
        else        sync_q <= {sync_q[0], pad_in};
    end

    assign sensed = sync_q[1] & ~cfg.sense_off;

    // Assemble the read words from the stored fields.
    always_comb begin
        rd1          = '0;
        rd1[C1_OUT]  = cfg.out_lvl;
        rd1[C1_IN]   = sensed;
        rd1[C1_TRIG] = cfg.trig_lvl;
        rd1[C1_INV]  = cfg.trig_inv;
        rd1[C1_DIR]  = cfg.dir_in;
        rd1[C1_USE]  = cfg.use_gpio;
        rd2           = '0;
        rd2[C2_NOSNS] = cfg.sense_off;
        rd2[1:0]      = cfg.pull;
    end

    assign pad_oe  = cfg.use_gpio & ~cfg.dir_in;
    assign pad_out = pad_oe & cfg.out_lvl;

endmodule

// File: rtl/gpcfg_bank.sv
// Top: GPIO configuration register bank. Holds the ownership bitmap, the
// interrupt line select and one gpcfg_pin per pin; reads are combinational.
// Assumes a single-cycle write strobe and word-aligned addresses.
module gpcfg_bank
    import gpcfg_pkg::*;
#(
    parameter int NUM_PINS = 94,
    parameter int ADDR_W   = 12,
    parameter logic [((NUM_PINS + 31) / 32) * 32 - 1:0] OWN_INIT = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq_sel
);

    localparam int OWN_WORDS = (NUM_PINS + 31) / 32;
    localparam int PIN_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam int OWN_IW    = (OWN_WORDS > 1) ? $clog2(OWN_WORDS) : 1;

    function automatic logic [31:0] own_mask(input int w);
        logic [31:0] m;
        for (int b = 0; b < 32; b++) m[b] = ((w * 32 + b) < NUM_PINS);
        return m;
    endfunction

    sel_e              sel;
    logic [PIN_W-1:0]  pin;
    logic [OWN_IW-1:0] word;
    logic [31:0]       own_q [OWN_WORDS];
    logic              ctl_q;
    logic [31:0]       rd1 [NUM_PINS];
    logic [31:0]       rd2 [NUM_PINS];

    gpcfg_decode #(
        .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .OWN_WORDS(OWN_WORDS),
        .PIN_W(PIN_W), .OWN_IW(OWN_IW)
    ) i_decode (
        .addr(addr), .sel(sel), .pin(pin), .word(word)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        gpcfg_pin i_pin (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr1    (wr_en && sel == SEL_CFG1 && pin == PIN_W'(p)),
            .wr2    (wr_en && sel == SEL_CFG2 && pin == PIN_W'(p)),
            .wdata  (wdata),
            .pad_in (pad_in[p]),
            .rd1    (rd1[p]),
            .rd2    (rd2[p]),
            .pad_out(pad_out[p]),
            .pad_oe (pad_oe[p])
        );
    end

    // Ownership bitmap words, preset from the parameter.
    for (genvar w = 0; w < OWN_WORDS; w++) begin : g_own
        always_ff @(posedge clk) begin
            if (!rst_n)
                own_q[w] <= OWN_INIT[w*32 +: 32] & own_mask(w);
            else if (wr_en && sel == SEL_OWN && word == OWN_IW'(w))
                own_q[w] <= wdata & own_mask(w);
        end
    end

    // Host interrupt line select.
    always_ff @(posedge clk) begin
        if (!rst_n)                        ctl_q <= 1'b0;
        else if (wr_en && sel == SEL_CTL)  ctl_q <= wdata[0];
    end

    assign irq_sel = ctl_q;

    // Read multiplexer.
    always_comb begin
        unique case (sel)
            SEL_OWN:  rdata = own_q[word];
            SEL_CTL:  rdata = {31'b0, ctl_q};
            SEL_CFG1: rdata = rd1[pin];
            SEL_CFG2: rdata = rd2[pin];
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpcfg_bank_chk.sv
// Checker for gpcfg_bank: observes ports only and checks the address map
// boundaries, reserved bits, pad stability and reset state.
module gpcfg_bank_chk #(
    parameter int NUM_PINS = 94,
    parameter int ADDR_W   = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [31:0]         rdata,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic                irq_sel
);

    localparam int unsigned OWN_END = ((NUM_PINS + 31) / 32) * 4;
    localparam int unsigned PIN_END = 32'h100 + NUM_PINS * 8;

    logic [31:0] a32;
    logic        in_pins;
    logic        oob;
    logic        is_ctl;

    assign a32     = 32'({addr[ADDR_W-1:2], 2'b00});
    assign in_pins = (a32 >= 32'h100) && (a32 < PIN_END);
    assign is_ctl  = (a32 == 32'h7C);
    assign oob     = !in_pins && !is_ctl && (a32 >= OWN_END);

    // R2: outputs are quiet in the first cycle out of reset
    a_r2_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pad_oe == '0 && pad_out == '0 && !irq_sel));

    // R3: reserved bits of the first config word read zero
    a_r3_cfg1_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pins && !a32[2]) |-> ((rdata & ~32'hC000_001D) == 32'h0));

    // R4: reserved bits of the second config word read zero
    a_r4_cfg2_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pins && a32[2]) |-> ((rdata & ~32'h0000_0007) == 32'h0));

    // R5: pads move only on the edge completing a write
    a_r5_pads_need_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(pad_oe) && $stable(pad_out)));

    // R8: the line select changes only through the control word
    a_r8_sel_by_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || !is_ctl) |=> $stable(irq_sel));

    // R9: unmapped addresses read zero
    a_r9_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        oob |-> (rdata == 32'h0));

    // R9: writes to unmapped addresses leave every output unchanged
    a_r9_oob_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && oob) |=> ($stable(pad_oe) && $stable(pad_out) && $stable(irq_sel)));

endmodule

bind gpcfg_bank gpcfg_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .rdata(rdata),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_sel(irq_sel)
);

// File: tb/test_gpcfg_bank.sv
// Bench for gpcfg_bank: directed corner cases plus seeded random register
// traffic, checked against a model kept in bench variables.
module test_gpcfg_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 94;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic          irq_sel;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [31:0] m_c1 [NP];
    logic [31:0] m_c2 [NP];
    logic [95:0] m_own;
    logic        m_ctl;

    gpcfg_bank #(.NUM_PINS(NP), .ADDR_W(AW)) i_gpcfg_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .irq_sel(irq_sel)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input int unsigned a);
        int unsigned p;
        if (a < 12) return m_own[(a / 4) * 32 +: 32];
        if (a == 32'h7C) return {31'b0, m_ctl};
        if (a >= 32'h100) begin
            p = (a - 32'h100) / 8;
            if (p < NP) begin
                if (a[2]) return m_c2[p];
                return m_c1[p] | ({31'b0, pad_in[p] & ~m_c2[p][2]} << 30);
            end
        end
        return 32'h0;
    endfunction

    task automatic model_write(input int unsigned a, input logic [31:0] d);
        int unsigned p;
        if (a < 12) begin
            m_own[(a / 4) * 32 +: 32] = d;
            m_own[95:NP] = '0;
        end else if (a == 32'h7C) m_ctl = d[0];
        else if (a >= 32'h100) begin
            p = (a - 32'h100) / 8;
            if (p < NP) begin
                if (a[2]) m_c2[p] = d & 32'h7;
                else      m_c1[p] = d & 32'h8000_001D;
            end
        end
    endtask

    function automatic logic [NP-1:0] exp_oe();
        logic [NP-1:0] v;
        for (int p = 0; p < NP; p++) v[p] = m_c1[p][0] & ~m_c1[p][2];
        return v;
    endfunction

    function automatic logic [NP-1:0] exp_out();
        logic [NP-1:0] v;
        for (int p = 0; p < NP; p++) v[p] = m_c1[p][0] & ~m_c1[p][2] & m_c1[p][31];
        return v;
    endfunction

    // Write at a falling edge; returns at the falling edge after the write edge.
    task automatic wr(input int unsigned a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd_chk(input string req, input int unsigned a);
        addr = AW'(a);
        #1;
        chk(req, 128'(rdata), 128'(exp_read(a)));
    endtask

    task automatic pads_chk(input string req);
        chk(req, 128'(pad_oe), 128'(exp_oe()));
        chk(req, 128'(pad_out), 128'(exp_out()));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [95:0] rnd;
        void'($urandom(32'd1234));
        for (int p = 0; p < NP; p++) begin
            m_c1[p] = 32'h4; m_c2[p] = 32'h4;
        end
        m_own = {2'b00, {NP{1'b1}}};
        m_ctl = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset values
        rd_chk("R2", 32'h100);
        rd_chk("R2", 32'h100 + 93 * 8 + 4);
        rd_chk("R2", 32'h08);
        rd_chk("R2", 32'h7C);
        pads_chk("R2");
        chk("R2", 128'(irq_sel), 128'(0));

        // R5: GPIO output drive and release
        wr(32'h100 + 5 * 8, 32'h8000_0001);
        pads_chk("R5");
        chk("R5", 128'(pad_oe[5]), 128'(1));
        wr(32'h100 + 5 * 8, 32'h8000_0005);
        pads_chk("R5");
        wr(32'h100 + 6 * 8, 32'h8000_0000);
        chk("R5", 128'(pad_oe[6]), 128'(0));

        // R3: reserved bits ignore writes
        wr(32'h100 + 7 * 8, 32'hFFFF_FFFF);
        rd_chk("R3", 32'h100 + 7 * 8);

        // R4: second word field set
        wr(32'h100 + 8 * 8 + 4, 32'hFFFF_FFFA);
        rd_chk("R4", 32'h100 + 8 * 8 + 4);

        // R6: two-edge lag, sense gating, read-only bit
        wr(32'h100 + 10 * 8 + 4, 32'h0);
        wr(32'h100 + 10 * 8, 32'h4000_0004);
        addr = AW'(32'h100 + 10 * 8);
        #1;
        chk("R6 write ignored", 128'(rdata[30]), 128'(0));
        @(negedge clk);
        pad_in[10] = 1'b1;
        @(negedge clk);
        #1;
        chk("R6 one edge", 128'(rdata[30]), 128'(0));
        @(negedge clk);
        #1;
        chk("R6 two edges", 128'(rdata[30]), 128'(1));
        wr(32'h100 + 10 * 8 + 4, 32'h4);
        addr = AW'(32'h100 + 10 * 8);
        #1;
        chk("R6 sense off", 128'(rdata[30]), 128'(0));

        // R8: line select
        wr(32'h7C, 32'hFFFF_FFFF);
        chk("R8", 128'(irq_sel), 128'(1));
        rd_chk("R8", 32'h7C);

        // R7: ownership past the last pin
        wr(32'h08, 32'hFFFF_FFFF);
        rd_chk("R7", 32'h08);
        wr(32'h04, 32'h0);
        rd_chk("R7", 32'h04);

        // R9: writes past the last pin and into the gap
        wr(32'h100 + 94 * 8, 32'hFFFF_FFFF);
        rd_chk("R9", 32'h100 + 94 * 8);
        pads_chk("R9");
        wr(32'h0C, 32'hFFFF_FFFF);
        rd_chk("R9", 32'h0C);
        rd_chk("R9", 32'h7C);

        // R1: random traffic against the model
        for (int it = 0; it < 600; it++) begin
            int unsigned a;
            if (it % 60 == 0) begin
                rnd = {$urandom, $urandom, $urandom};
                pad_in = rnd[NP-1:0];
                repeat (3) @(negedge clk);
            end
            case ($urandom_range(0, 5))
                0: a = 4 * $urandom_range(0, 3);
                1: a = 32'h7C;
                2, 3: a = 32'h100 + 8 * $urandom_range(0, 99) + 4 * $urandom_range(0, 1);
                4: a = 4 * $urandom_range(4, 62);
                default: a = 32'h100 + 8 * $urandom_range(94, 127) + 4 * $urandom_range(0, 1);
            endcase
            wr(a, $urandom);
            rd_chk("R1", a);
            pads_chk("R5");
            chk("R8", 128'(irq_sel), 128'(m_ctl));
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule